// File: doc/BRIEF.md
# Set-Associative Cache Hit/Miss Statistics Engine

This block models only the tag state of a set-associative cache. It has no data storage. It takes in memory-access trace records one at a time over a valid/ready handshake. Each record carries a two-bit operation code and a 64-bit address. For every lookup it produces a one-cycle result strobe with hit, miss and eviction flags, and it keeps three running counters: hits, misses and evictions. The number of sets (`2^SET_BITS`), the number of ways (`WAYS`) and the number of byte-offset bits (`OFS_BITS`) are parameters.

Instruction-fetch records are accepted and then ignored. Load and store records cause one lookup each. A modify record causes two lookups of the same address, one after the other. Replacement is least-recently-used, based on a per-line last-use stamp. A stamp counter advances once for every accepted record.

The control is a state machine with three states:
- `ST_IDLE` drives `in_ready` high and accepts a record.
- `ST_LOOKUP` reads the addressed set and registers the outcome of the tag compare.
- `ST_COMMIT` writes the chosen line, pulses the strobe and updates the counters.

The transitions are:
- `accept_instr`: IDLE→IDLE.
- `accept_access`: IDLE→LOOKUP.
- `resolve`: LOOKUP→COMMIT.
- `modify_again`: COMMIT→LOOKUP, taken after the first half of a modify.
- `done`: COMMIT→IDLE.

Top module: `cache_stat_engine`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), all three counters read 0, `in_ready` is 1, `res_valid` is 0, and every line is invalid, with tag 0 and stamp 0.
- R2: A record with `in_op` = 2'b00 (instruction fetch) is accepted but performs no lookup. It produces no strobe, leaves all counters unchanged and keeps `in_ready` high on the next cycle.
- R3: A record with `in_op` = 2'b01 (load) or 2'b10 (store) performs exactly one lookup. That lookup gives one strobe, with exactly one of `res_hit` or `res_miss` set.
- R4: A record with `in_op` = 2'b11 (modify) performs two lookups of the same address. The second lookup is always a hit, and `in_ready` stays low until both have finished.
- R5: The set index is bits [OFS_BITS+SET_BITS-1 : OFS_BITS] of the address. The tag is the address shifted right by OFS_BITS+SET_BITS. The offset bits have no effect on any outcome.
- R6: A hit makes the matching line's stamp equal to the current record's stamp and increments `hit_cnt` by one.
- R7: A miss while the set has an invalid way fills the lowest-numbered invalid way. It raises `res_miss`, increments `miss_cnt`, and leaves `res_evict` low.
- R8: A miss in a full set replaces the valid way with the smallest stamp, choosing the lowest-numbered way on a tie. It raises both `res_miss` and `res_evict` and increments both `miss_cnt` and `evict_cnt`.
- R9: The stamp advances by one for each accepted record, including instruction fetches. Both lookups of a modify use the same stamp.
- R10: The strobe for a lookup appears in the second cycle after the record is accepted (or after the previous lookup of a modify). The counters show that lookup from the following cycle onward. All-zero flags accompany a low `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A trace record is offered |
| in_ready | output | 1 | The engine can accept a record |
| in_op | input | 2 | Operation: 00 instr, 01 load, 10 store, 11 modify |
| in_addr | input | ADDR_W | Access address |
| res_valid | output | 1 | One-cycle strobe per lookup |
| res_hit | output | 1 | The lookup hit |
| res_miss | output | 1 | The lookup missed |
| res_evict | output | 1 | The miss replaced a valid line |
| hit_cnt | output | CNT_W | Running hit count |
| miss_cnt | output | CNT_W | Running miss count |
| evict_cnt | output | CNT_W | Running eviction count |

## Verification
The checker watches several rules on every cycle:
- each strobe carries exactly one of hit or miss;
- an eviction only ever comes with a miss;
- the flags stay quiet outside a strobe;
- each counter steps by exactly one with its flag and holds otherwise;
- an instruction record never stalls the input;
- an access record always does stall it.

Other behaviour depends on history and can only be shown by the bench's scenarios, which compare each strobe and the counters against a reference model. This covers which way is filled or replaced, the LRU choice among full sets, the offset bits having no effect, and a modify's second lookup hitting.

// File: rtl/cse_pkg.sv
package cse_pkg;

    typedef enum logic [1:0] {
        OP_INSTR  = 2'b00,
        OP_LOAD   = 2'b01,
        OP_STORE  = 2'b10,
        OP_MODIFY = 2'b11
    } rec_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_COMMIT = 2'd2
    } eng_state_e;

endpackage

// File: rtl/cse_tag_store.sv
module cse_tag_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 58,
    parameter int TS_W  = 32,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0][TS_W-1:0]   rd_ts,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [TS_W-1:0]             wr_ts
);

    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][TS_W-1:0]   ts_q;

    // Line state: one generate branch per set and way
    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                    ts_q[s][w]    <= '0;
                end else if (wr_en && wr_set == SET_W'(s) && wr_way == WAY_W'(w)) begin
                    valid_q[s][w] <= 1'b1;
                    tag_q[s][w]   <= wr_tag;
                    ts_q[s][w]    <= wr_ts;
                end
            end
        end
    end

    assign rd_valid = valid_q[rd_set];
    assign rd_tag   = tag_q[rd_set];
    assign rd_ts    = ts_q[rd_set];

endmodule

// File: rtl/cse_way_select.sv
module cse_way_select #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 58,
    parameter int TS_W  = 32,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
    input  logic [WAYS-1:0][TS_W-1:0]   set_ts,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        is_hit,
    output logic                        needs_evict,
    output logic [WAY_W-1:0]            pick_way
);

    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;
    logic             any_free;

    always_comb begin
        is_hit   = 1'b0;
        hit_way  = '0;
        any_free = 1'b0;
        free_way = '0;
        old_way  = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (set_valid[i] && set_tag[i] == look_tag && !is_hit) begin
                is_hit  = 1'b1;
                hit_way = WAY_W'(i);
            end
            if (!set_valid[i] && !any_free) begin
                any_free = 1'b1;
                free_way = WAY_W'(i);
            end
            // strict less-than keeps the lowest way on equal stamps
            if (set_ts[i] < set_ts[old_way]) begin
                old_way = WAY_W'(i);
            end
        end
        needs_evict = !is_hit && !any_free;
        if (is_hit)        pick_way = hit_way;
        else if (any_free) pick_way = free_way;
        else               pick_way = old_way;
    end

endmodule

// File: rtl/cse_stat_counters.sv
module cse_stat_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_hit,
    input  logic             bump_miss,
    input  logic             bump_evict,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt,
    output logic [CNT_W-1:0] evict_cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt   <= '0;
            miss_cnt  <= '0;
            evict_cnt <= '0;
        end else begin
            if (bump_hit)   hit_cnt   <= hit_cnt + 1'b1;
            if (bump_miss)  miss_cnt  <= miss_cnt + 1'b1;
            if (bump_evict) evict_cnt <= evict_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cache_stat_engine.sv
module cache_stat_engine
    import cse_pkg::*;
#(
    parameter int SET_BITS = 2,
    parameter int WAYS     = 2,
    parameter int OFS_BITS = 4,
    parameter int ADDR_W   = 64,
    parameter int CNT_W    = 32,
    parameter int TS_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_evict,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt,
    output logic [CNT_W-1:0]  evict_cnt
);

    localparam int SETS   = 1 << SET_BITS;
    localparam int TAG_W  = ADDR_W - SET_BITS - OFS_BITS;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LINE_W = ADDR_W - OFS_BITS;

    eng_state_e state_q, state_d;

    logic [LINE_W-1:0] line_q;
    logic [TS_W-1:0]   stamp_q;
    logic [TS_W-1:0]   rec_ts_q;
    logic              mod_q;
    logic              second_q;
    logic              hit_q, evict_q;
    logic [WAY_W-1:0]  way_q;

    logic                       accept;
    logic [SET_BITS-1:0]        cur_set;
    logic [TAG_W-1:0]           cur_tag;
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0][TAG_W-1:0] set_tag;
    logic [WAYS-1:0][TS_W-1:0]  set_ts;
    logic                       sel_hit, sel_evict;
    logic [WAY_W-1:0]           sel_way;
    logic                       commit;

    assign accept  = in_valid && in_ready;
    assign cur_set = line_q[SET_BITS-1:0];
    assign cur_tag = line_q[LINE_W-1:SET_BITS];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && rec_op_e'(in_op) != OP_INSTR) state_d = ST_LOOKUP; // accept_access
            end
            ST_LOOKUP: state_d = ST_COMMIT;                                    // resolve
            ST_COMMIT: state_d = (mod_q && !second_q) ? ST_LOOKUP : ST_IDLE;   // modify_again / done
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE:   in_ready = 1'b1;
            ST_LOOKUP: ;
            ST_COMMIT: commit = 1'b1;
            default:   ;
        endcase
        res_valid = commit;
        res_hit   = commit && hit_q;
        res_miss  = commit && !hit_q;
        res_evict = commit && evict_q;
    end

    // Record capture and stamp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q  <= '0;
            rec_ts_q <= '0;
            line_q   <= '0;
            mod_q    <= 1'b0;
            second_q <= 1'b0;
        end else begin
            if (accept) begin
                stamp_q  <= stamp_q + 1'b1;
                rec_ts_q <= stamp_q + 1'b1;
                line_q   <= in_addr[ADDR_W-1:OFS_BITS];
                mod_q    <= rec_op_e'(in_op) == OP_MODIFY;
                second_q <= 1'b0;
            end else if (commit) begin
                second_q <= 1'b1;
            end
        end
    end

    // Lookup result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            evict_q <= 1'b0;
            way_q   <= '0;
        end else if (state_q == ST_LOOKUP) begin
            hit_q   <= sel_hit;
            evict_q <= sel_evict;
            way_q   <= sel_way;
        end
    end

    cse_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .TS_W(TS_W),
        .SET_W(SET_BITS), .WAY_W(WAY_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (cur_set),
        .rd_valid (set_valid),
        .rd_tag   (set_tag),
        .rd_ts    (set_ts),
        .wr_en    (commit),
        .wr_set   (cur_set),
        .wr_way   (way_q),
        .wr_tag   (cur_tag),
        .wr_ts    (rec_ts_q)
    );

    cse_way_select #(
        .WAYS(WAYS), .TAG_W(TAG_W), .TS_W(TS_W), .WAY_W(WAY_W)
    ) u_select (
        .set_valid   (set_valid),
        .set_tag     (set_tag),
        .set_ts      (set_ts),
        .look_tag    (cur_tag),
        .is_hit      (sel_hit),
        .needs_evict (sel_evict),
        .pick_way    (sel_way)
    );

    cse_stat_counters #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .bump_hit   (res_hit),
        .bump_miss  (res_miss),
        .bump_evict (res_evict),
        .hit_cnt    (hit_cnt),
        .miss_cnt   (miss_cnt),
        .evict_cnt  (evict_cnt)
    );

endmodule

// File: rtl/cse_checker.sv
module cse_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_op,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_miss,
    input logic             res_evict,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt,
    input logic [CNT_W-1:0] evict_cnt
);

    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_miss}) == 1);

    a_r8_evict_with_miss: assert property (@(posedge clk) disable iff (!rst_n)
        res_evict |-> res_valid && res_miss);

    a_r10_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_hit && !res_miss && !res_evict);

    a_r6_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |=> hit_cnt == $past(hit_cnt) + 1'b1);

    a_r7_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |=> miss_cnt == $past(miss_cnt) + 1'b1);

    a_r8_evict_step: assert property (@(posedge clk) disable iff (!rst_n)
        res_evict |=> evict_cnt == $past(evict_cnt) + 1'b1);

    a_r2_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(hit_cnt) && $stable(miss_cnt) && $stable(evict_cnt));

    a_r2_instr_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_op == 2'b00 |=> in_ready && !res_valid);

    a_r4_access_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_op != 2'b00 |=> !in_ready);

endmodule

bind cache_stat_engine cse_checker #(.CNT_W(CNT_W)) u_cse_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_evict (res_evict),
    .hit_cnt   (hit_cnt),
    .miss_cnt  (miss_cnt),
    .evict_cnt (evict_cnt)
);

// File: tb/tb_cache_stat_engine.sv
module tb_cache_stat_engine;

    localparam int SET_BITS = 2;
    localparam int WAYS     = 2;
    localparam int OFS_BITS = 4;
    localparam int SETS     = 1 << SET_BITS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] in_addr = '0;
    logic        res_valid, res_hit, res_miss, res_evict;
    logic [31:0] hit_cnt, miss_cnt, evict_cnt;

    always #4 clk = ~clk;

    cache_stat_engine #(.SET_BITS(SET_BITS), .WAYS(WAYS), .OFS_BITS(OFS_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_miss(res_miss), .res_evict(res_evict), .hit_cnt(hit_cnt),
        .miss_cnt(miss_cnt), .evict_cnt(evict_cnt)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference model
    bit          m_valid [SETS][WAYS];
    logic [63:0] m_tag   [SETS][WAYS];
    int unsigned m_ts    [SETS][WAYS];
    int unsigned m_stamp;
    int unsigned e_hit, e_miss, e_evict;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = 0; m_ts[s][w] = 0;
            end
        m_stamp = 0; e_hit = 0; e_miss = 0; e_evict = 0;
    endtask

    // returns {hit, miss, evict}
    function automatic logic [2:0] model_lookup(input logic [63:0] a, input int unsigned ts);
        int s;
        logic [63:0] t;
        int lru;
        s = int'((a >> OFS_BITS) & (SETS - 1));
        t = a >> (OFS_BITS + SET_BITS);
        for (int w = 0; w < WAYS; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) begin
                m_ts[s][w] = ts; e_hit++;
                return 3'b100;
            end
        e_miss++;
        for (int w = 0; w < WAYS; w++)
            if (!m_valid[s][w]) begin
                m_valid[s][w] = 1; m_tag[s][w] = t; m_ts[s][w] = ts;
                return 3'b010;
            end
        lru = 0;
        for (int w = 1; w < WAYS; w++) if (m_ts[s][w] < m_ts[s][lru]) lru = w;
        m_tag[s][lru] = t; m_ts[s][lru] = ts; e_evict++;
        return 3'b011;
    endfunction

    task automatic send(input logic [1:0] op, input logic [63:0] a, input string req);
        logic [2:0] exp [2];
        int n, k, guard;
        m_stamp++;
        n = (op == 2'b00) ? 0 : (op == 2'b11) ? 2 : 1;
        for (int i = 0; i < n; i++) exp[i] = model_lookup(a, m_stamp);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_addr = a;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        k = 0; guard = 0;
        if (n == 0) check({req, " R2 ready stays high"}, 64'(in_ready), 64'd1);
        while (!(in_ready && k == n)) begin
            if (res_valid) begin
                if (k < n) check({req, " R3 flags"}, 64'({res_hit, res_miss, res_evict}), 64'(exp[k]));
                else       check({req, " R3 extra strobe"}, 64'd1, 64'd0);
                k++;
            end
            if (in_ready && k < n) begin
                check({req, " R10 ready before strobe"}, 64'(k), 64'(n));
                break;
            end
            guard++;
            if (guard > 20) begin
                check({req, " watchdog"}, 64'd0, 64'd1);
                break;
            end
            @(negedge clk);
        end
        if (n == 0) check({req, " R2 no strobe"}, 64'(res_valid), 64'd0);
        check({req, " R6 hit_cnt"},   64'(hit_cnt),   64'(e_hit));
        check({req, " R7 miss_cnt"},  64'(miss_cnt),  64'(e_miss));
        check({req, " R8 evict_cnt"}, 64'(evict_cnt), 64'(e_evict));
    endtask

    function automatic logic [63:0] mk(input int tag, input int set, input int ofs);
        return (64'(tag) << (OFS_BITS + SET_BITS)) | (64'(set) << OFS_BITS) | 64'(ofs);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 64'(in_ready), 64'd1);
        check("R1 res_valid", 64'(res_valid), 64'd0);
        check("R1 hit_cnt", 64'(hit_cnt), 64'd0);
        check("R1 miss_cnt", 64'(miss_cnt), 64'd0);
        check("R1 evict_cnt", 64'(evict_cnt), 64'd0);

        // R7 fill lowest invalid way, R5 offset ignored, R8 LRU replacement
        send(2'b01, mk(5, 1, 0),   "R7 first fill");
        send(2'b10, mk(9, 1, 3),   "R7 second fill");
        send(2'b01, mk(5, 1, 15),  "R5 offset differs hit");
        send(2'b00, mk(7, 1, 0),   "R2 instr");
        send(2'b01, mk(11, 1, 2),  "R8 evict LRU tag9");
        send(2'b01, mk(9, 1, 0),   "R8 evict LRU tag5");
        send(2'b01, mk(11, 1, 0),  "R6 hit after refill");
        // R4 modify: miss then hit, and hit-hit
        send(2'b11, mk(3, 2, 4),   "R4 modify miss+hit");
        send(2'b11, mk(3, 2, 8),   "R4 modify hit+hit");
        send(2'b11, mk(13, 1, 0),  "R4 modify evict+hit");
        // R9 stamp shared by modify: tag13 now newest; next miss evicts tag11? model decides
        send(2'b01, mk(20, 1, 0),  "R9 LRU after modify");

        // mixed random stream over a small tag pool to force conflicts
        for (int i = 0; i < 400; i++) begin
            send(2'($urandom_range(0, 3)),
                 mk(int'($urandom_range(0, 5)), int'($urandom_range(0, SETS - 1)),
                    int'($urandom_range(0, (1 << OFS_BITS) - 1))),
                 "R3 random");
        end

        // R1 reset clears lines and counters
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check("R1 counters after reset", 64'(hit_cnt + miss_cnt + evict_cnt), 64'd0);
        send(2'b01, mk(0, 0, 0), "R1 line 0 starts invalid");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule